// File: doc/BRIEF.md
# Two-Byte-Address Serial EEPROM Transfer Sequencer

This block turns one transfer request into the ordered series of byte-level operations needed to write or read a serial EEPROM whose memory location takes sixteen bits. It sits above a byte engine that performs a single start, byte write, byte read or stop at a time, and below a client that supplies the device-select bits, the location, a byte count and a direction. Write data comes in through a valid/ready byte port and read data leaves through another one, so either side may stall.

A write sends the control byte, both location bytes and the data bytes. A read first sets the internal pointer with a dummy write, then sends a repeated start and a read control byte, and then receives the data. In fast mode, every transfer begins with a master-code preamble. If the engine reports a missing acknowledge or a failed step, the sequencer abandons the rest of the transfer, still closes it with a stop, and flags an error together with its completion pulse.

Top module: `i2c_eep_seq`

## Requirements
- R1: A request is taken only in a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high exactly when `busy` is low. `busy` rises in the cycle after acceptance and stays high until the stop completes. `req_valid` while busy has no effect.
- R2: The control byte is binary 1010, then `req_sel[2:0]`, then a direction bit in bit 0 that is 0 for the address/write phase and 1 for the read phase.
- R3: The location goes out directly after the write control byte as two bytes: `req_loc[15:8]` first, then `req_loc[7:0]`.
- R4: Engine operation codes on `eng_op` are 0 start, 1 write byte, 2 read byte and 3 stop. A write issues start, control (write), location high, location low, then one write per data byte in the order taken from the write port, then stop. A count of 0 sends the location only.
- R5: A read issues start, control (write), both location bytes, a repeated start, control (read), `req_len` byte reads and a stop. The received bytes appear on the read port in order and are held while `rd_ready` is low. A count of 0 stops right after the location bytes.
- R6: On each byte read, `eng_ack` is 1 (send acknowledge) except on the last byte of the transfer, where it is 0. A one-byte read therefore uses 0 on its only byte.
- R7: With `req_fast` high, start and a write of 0x09 come before the normal start. A missing acknowledge on 0x09 is not an error, and `bus_busy` is not waited on.
- R8: With `req_fast` low, no operation is issued while `bus_busy` is high before the first start.
- R9: A missing acknowledge (`eng_nack`) on any byte the sequencer writes other than 0x09, or an `eng_fail` on any step, ends the transfer. No further bytes are sent and a stop is issued next.
- R10: `done` is a one-cycle pulse in the first idle cycle after the stop completes. `error` is 1 in that cycle if R9 applied and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_fast | input | 1 | Send the master-code preamble, skip the bus-free wait |
| req_sel | input | 3 | Device-select bits of the control byte |
| req_loc | input | 16 | Memory location |
| req_len | input | LEN_W | Number of data bytes |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken when both high |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Client takes read byte |
| rd_data | output | 8 | Read byte |
| bus_busy | input | 1 | Bus in use by another master |
| eng_req | output | 1 | Operation request to byte engine, held until `eng_done` |
| eng_op | output | 2 | Operation code |
| eng_byte | output | 8 | Byte to write |
| eng_ack | output | 1 | Acknowledge to send after a byte read |
| eng_done | input | 1 | One-cycle operation completion |
| eng_nack | input | 1 | Device did not acknowledge the written byte |
| eng_fail | input | 1 | Operation failed |
| eng_rbyte | input | 8 | Byte received, valid with `eng_done` |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished pulse |
| error | output | 1 | Transfer ended by a fault |

## Verification
A wrong state in the step machine shows at once in the next operation on the engine port: a swapped location byte, a missing repeated start or a wrong direction bit in the control byte shows in the first few logged operations, well before `done`. A wrong remaining-byte count shows as an extra or missing data operation, or as the acknowledge flag dropping on the wrong read. A lost error path shows as further bytes after a refused byte, or as `error` low in the `done` cycle. Holding `bus_busy` or stalling the byte ports shows whether the machine waits in the right place rather than skipping ahead.

// File: rtl/eepseq_pkg.sv
package eepseq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_WAITBUS, S_HSS, S_HSC, S_START, S_CTRLW, S_AHI, S_ALO,
    S_WFETCH, S_WDATA, S_RSTART, S_CTRLR, S_RDATA, S_RWAIT, S_STOP
  } seq_state_e;

  localparam logic [7:0] MASTER_CODE = 8'h09;

  function automatic logic [7:0] ctrl_byte(input logic [3:0] dtype,
                                           input logic [2:0] sel,
                                           input logic rd);
    return {dtype, sel, rd};
  endfunction

  function automatic logic [7:0] loc_high(input logic [15:0] loc);
    return loc[15:8];
  endfunction

  function automatic logic [7:0] loc_low(input logic [15:0] loc);
    return loc[7:0];
  endfunction

endpackage

// File: rtl/eepseq_left_ctr.sv
module eepseq_left_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero,
  output logic         one
);
  logic [W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec)  left_q <= left_q - 1'b1;
  end

  assign zero = (left_q == '0);
  assign one  = (left_q == W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !zero); // R4
endmodule

// File: rtl/eepseq_rd_buf.sv
module eepseq_rd_buf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= 8'h00;
    end else if (load) begin
      rd_valid <= 1'b1;
      rd_data  <= din;
    end else if (rd_valid && rd_ready) begin
      rd_valid <= 1'b0;
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R5
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !rd_valid); // R5
endmodule

// File: rtl/eepseq_status.sv
module eepseq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic set_err,
  input  logic fin,
  output logic done,
  output logic error
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      done <= fin;
      if (accept)       error <= 1'b0;
      else if (set_err) error <= 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

// File: rtl/i2c_eep_seq.sv
module i2c_eep_seq
  import eepseq_pkg::*;
#(
  parameter int         LEN_W    = 8,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_fast,
  input  logic [2:0]       req_sel,
  input  logic [15:0]      req_loc,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  input  logic             bus_busy,
  output logic             eng_req,
  output logic [1:0]       eng_op,
  output logic [7:0]       eng_byte,
  output logic             eng_ack,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic             eng_fail,
  input  logic [7:0]       eng_rbyte,
  output logic             busy,
  output logic             done,
  output logic             error
);
  seq_state_e  state_q, state_d;
  logic        is_read_q;
  logic [2:0]  sel_q;
  logic [15:0] loc_q;
  logic [7:0]  wbyte_q;
  bus_op_e     op_w;

  // named internal events
  logic accept_w, step_bad, step_ok, left_zero, left_one;
  logic data_step, rd_load, stop_done, wr_take;

  assign req_ready = (state_q == S_IDLE);
  assign busy      = !req_ready;
  assign accept_w  = req_valid && req_ready;

  assign step_bad  = eng_done && (eng_fail ||
                     (eng_nack && op_w == OP_WRITE && state_q != S_HSC));
  assign step_ok   = eng_done && !step_bad;
  assign data_step = step_ok && (state_q == S_WDATA || state_q == S_RDATA);
  assign rd_load   = step_ok && (state_q == S_RDATA);
  assign stop_done = eng_done && (state_q == S_STOP);
  assign wr_ready  = (state_q == S_WFETCH) && !left_zero;
  assign wr_take   = wr_ready && wr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      is_read_q <= 1'b0;
      sel_q     <= '0;
      loc_q     <= '0;
      wbyte_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept_w) begin
        is_read_q <= !req_write;
        sel_q     <= req_sel;
        loc_q     <= req_loc;
      end
      if (wr_take) wbyte_q <= wr_data;
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (accept_w) state_d = req_fast ? S_HSS : S_WAITBUS;
      S_WAITBUS: if (!bus_busy) state_d = S_START;
      S_HSS:     if (step_ok) state_d = S_HSC;
      S_HSC:     if (step_ok) state_d = S_START;
      S_START:   if (step_ok) state_d = S_CTRLW;
      S_CTRLW:   if (step_ok) state_d = S_AHI;
      S_AHI:     if (step_ok) state_d = S_ALO;
      S_ALO:     if (step_ok) state_d = !is_read_q ? S_WFETCH :
                                        (left_zero ? S_STOP : S_RSTART);
      S_WFETCH:  if (left_zero) state_d = S_STOP;
                 else if (wr_valid) state_d = S_WDATA;
      S_WDATA:   if (step_ok) state_d = S_WFETCH;
      S_RSTART:  if (step_ok) state_d = S_CTRLR;
      S_CTRLR:   if (step_ok) state_d = S_RDATA;
      S_RDATA:   if (step_ok) state_d = S_RWAIT;
      S_RWAIT:   if (!rd_valid) state_d = left_zero ? S_STOP : S_RDATA;
      S_STOP:    if (eng_done) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
    if (step_bad && state_q != S_STOP) state_d = S_STOP;
  end

  always_comb begin
    eng_req  = 1'b1;
    op_w     = OP_WRITE;
    eng_byte = 8'h00;
    eng_ack  = 1'b0;
    unique case (state_q)
      S_HSS, S_START, S_RSTART: op_w = OP_START;
      S_HSC:   eng_byte = MASTER_CODE;
      S_CTRLW: eng_byte = ctrl_byte(DEV_TYPE, sel_q, 1'b0);
      S_CTRLR: eng_byte = ctrl_byte(DEV_TYPE, sel_q, 1'b1);
      S_AHI:   eng_byte = loc_high(loc_q);
      S_ALO:   eng_byte = loc_low(loc_q);
      S_WDATA: eng_byte = wbyte_q;
      S_RDATA: begin
        op_w    = OP_READ;
        eng_ack = !left_one;
      end
      S_STOP:  op_w = OP_STOP;
      default: begin
        eng_req = 1'b0;
        op_w    = OP_START;
      end
    endcase
  end
  assign eng_op = op_w;

  eepseq_left_ctr #(.W(LEN_W)) u_left (
    .clk(clk), .rst_n(rst_n), .load(accept_w), .load_val(req_len),
    .dec(data_step), .zero(left_zero), .one(left_one)
  );

  eepseq_rd_buf u_rbuf (
    .clk(clk), .rst_n(rst_n), .load(rd_load), .din(eng_rbyte),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  eepseq_status u_stat (
    .clk(clk), .rst_n(rst_n), .accept(accept_w), .set_err(step_bad),
    .fin(stop_done), .done(done), .error(error)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy); // R1
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_byte)
                             && $stable(eng_ack)); // R4
  AST_BAD_STEP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    step_bad && state_q != S_STOP |=> eng_req && eng_op == 2'd3); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_WAIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_WAITBUS |-> !eng_req); // R8
endmodule

// File: tb/i2c_eep_seq_test.sv
module i2c_eep_seq_test;
  typedef struct packed {
    logic        wr;
    logic        fast;
    logic [2:0]  sel;
    logic [15:0] loc;
    logic [7:0]  len;
    logic [7:0]  bad;
    logic        fail;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd5, 16'h1234, 8'd3, 8'd255, 1'b0},
    '{1'b0, 1'b0, 3'd2, 16'hBEEF, 8'd4, 8'd255, 1'b0},
    '{1'b0, 1'b0, 3'd0, 16'h00FF, 8'd1, 8'd255, 1'b0},
    '{1'b1, 1'b1, 3'd7, 16'h8001, 8'd2, 8'd255, 1'b0},
    '{1'b0, 1'b1, 3'd3, 16'h0F0F, 8'd2, 8'd255, 1'b0},
    '{1'b1, 1'b0, 3'd4, 16'hA55A, 8'd0, 8'd255, 1'b0},
    '{1'b0, 1'b0, 3'd6, 16'h5AA5, 8'd0, 8'd255, 1'b0},
    '{1'b1, 1'b0, 3'd1, 16'h0102, 8'd2, 8'd1,   1'b0},
    '{1'b1, 1'b0, 3'd1, 16'h0304, 8'd3, 8'd5,   1'b0},
    '{1'b0, 1'b0, 3'd2, 16'h0506, 8'd2, 8'd5,   1'b0},
    '{1'b0, 1'b0, 3'd3, 16'h0708, 8'd3, 8'd7,   1'b1},
    '{1'b1, 1'b1, 3'd4, 16'h090A, 8'd2, 8'd4,   1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fast = 1'b0;
  logic [2:0] req_sel = '0;
  logic [15:0] req_loc = '0;
  logic [7:0] req_len = '0;
  logic bus_busy = 1'b0;
  logic req_ready, wr_valid, wr_ready, rd_valid, rd_ready;
  logic [7:0] wr_data, rd_data, eng_byte, eng_rbyte;
  logic eng_req, eng_ack, eng_done, eng_nack, eng_fail, busy, done, error;
  logic [1:0] eng_op;

  always #10 clk = ~clk;

  i2c_eep_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_fast(req_fast), .req_sel(req_sel),
    .req_loc(req_loc), .req_len(req_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .bus_busy(bus_busy),
    .eng_req(eng_req), .eng_op(eng_op), .eng_byte(eng_byte),
    .eng_ack(eng_ack), .eng_done(eng_done), .eng_nack(eng_nack),
    .eng_fail(eng_fail), .eng_rbyte(eng_rbyte), .busy(busy), .done(done),
    .error(error)
  );

  // bench-side byte engine, write source and read sink
  logic clr = 1'b0, cfg_fast = 1'b0, cfg_fail = 1'b0;
  int   cfg_bad = 255;
  logic [1:0] lat;
  int   lidx, rcnt, widx, rn;
  logic [3:0] cyc;
  logic [1:0] log_op [64];
  logic [7:0] log_byte [64];
  logic       log_ack [64];
  logic [7:0] rcap [64];

  assign wr_valid = cyc[0];
  assign wr_data  = 8'hC0 + 8'(widx);
  assign rd_ready = cyc[1] | cyc[0];

  always @(posedge clk) begin
    cyc <= rst_n ? cyc + 4'd1 : 4'd0;
    if (!rst_n || clr) begin
      lat <= 2'd0; lidx <= 0; rcnt <= 0; widx <= 0; rn <= 0;
      eng_done <= 1'b0; eng_nack <= 1'b0; eng_fail <= 1'b0; eng_rbyte <= 8'h00;
    end else begin
      eng_done <= 1'b0; eng_nack <= 1'b0; eng_fail <= 1'b0;
      if (wr_valid && wr_ready) widx <= widx + 1;
      if (rd_valid && rd_ready && rn < 64) begin
        rcap[rn] <= rd_data; rn <= rn + 1;
      end
      if (eng_req && !eng_done) begin
        if (lat == 2'd2) begin
          lat <= 2'd0;
          eng_done <= 1'b1;
          if (lidx < 64) begin
            log_op[lidx] <= eng_op; log_byte[lidx] <= eng_byte; log_ack[lidx] <= eng_ack;
          end
          lidx <= lidx + 1;
          if (lidx == cfg_bad) begin
            if (cfg_fail) eng_fail <= 1'b1; else eng_nack <= 1'b1;
          end
          if (eng_op == 2'd1 && cfg_fast && lidx == 1) eng_nack <= 1'b1;
          if (eng_op == 2'd2) begin
            eng_rbyte <= 8'h30 + 8'(rcnt); rcnt <= rcnt + 1;
          end
        end else lat <= lat + 2'd1;
      end
    end
  end

  int nchk = 0, nerr = 0;
  logic [1:0] ex_op [64];
  logic [7:0] ex_byte [64];
  logic       ex_ack [64];
  string      ex_tag [64];
  int en, ex_reads;
  logic [1:0] t_op [64];
  logic [7:0] t_byte [64];
  logic       t_ack [64];
  string      t_tag [64];
  int tn;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] b, input logic a, input string tag);
    t_op[tn] = op; t_byte[tn] = b; t_ack[tn] = a; t_tag[tn] = tag; tn++;
  endtask

  // expected operation list, written from the requirements
  task automatic build(input vec_t v);
    tn = 0; en = 0; ex_reads = 0;
    if (v.fast) begin push(2'd0, 8'h00, 1'b0, "R7"); push(2'd1, 8'h09, 1'b0, "R7"); end
    push(2'd0, 8'h00, 1'b0, "R4");
    push(2'd1, {4'b1010, v.sel, 1'b0}, 1'b0, "R2");
    push(2'd1, v.loc[15:8], 1'b0, "R3");
    push(2'd1, v.loc[7:0], 1'b0, "R3");
    if (v.wr) begin
      for (int i = 0; i < int'(v.len); i++) push(2'd1, 8'hC0 + 8'(i), 1'b0, "R4");
    end else if (v.len != 0) begin
      push(2'd0, 8'h00, 1'b0, "R5");
      push(2'd1, {4'b1010, v.sel, 1'b1}, 1'b0, "R2");
      for (int i = 0; i < int'(v.len); i++) push(2'd2, 8'h00, (i != int'(v.len) - 1), "R6");
    end
    for (int i = 0; i < tn; i++) begin
      if (i <= int'(v.bad)) begin
        ex_op[en] = t_op[i]; ex_byte[en] = t_byte[i]; ex_ack[en] = t_ack[i]; ex_tag[en] = t_tag[i];
        en++;
        if (t_op[i] == 2'd2 && !(i == int'(v.bad))) ex_reads++;
      end
    end
    ex_op[en] = 2'd3; ex_byte[en] = 8'h00; ex_ack[en] = 1'b0;
    ex_tag[en] = (int'(v.bad) < tn) ? "R9" : "R4";
    en++;
  endtask

  task automatic prep(input vec_t v);
    @(negedge clk);
    clr = 1'b1; cfg_fast = v.fast; cfg_bad = int'(v.bad); cfg_fail = v.fail;
    @(negedge clk);
    clr = 1'b0;
    build(v);
  endtask

  task automatic launch(input vec_t v);
    req_write = v.wr; req_fast = v.fast; req_sel = v.sel; req_loc = v.loc; req_len = v.len;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output bit got, output logic err);
    got = 0; err = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin got = 1; err = error; break; end
    end
  endtask

  task automatic compare(input vec_t v, input bit got, input logic err, input string id);
    bit ok;
    check(got, {id, " R10 done pulse seen"}, got, 1);
    check(lidx == en, {id, " R4 R5 R9 operation count"}, lidx, en);
    ok = 1;
    for (int i = 0; i < en && i < lidx; i++) begin
      if (log_op[i] != ex_op[i] || (ex_op[i] == 2'd1 && log_byte[i] != ex_byte[i]) ||
          (ex_op[i] == 2'd2 && log_ack[i] != ex_ack[i])) begin
        if (ok)
          $display("FAIL %s %s step %0d op/byte/ack actual=%0h/%0h/%0h expected=%0h/%0h/%0h",
                   id, ex_tag[i], i, log_op[i], log_byte[i], log_ack[i],
                   ex_op[i], ex_byte[i], ex_ack[i]);
        ok = 0;
      end
    end
    nchk++;
    if (!ok) nerr++;
    check(err == (int'(v.bad) < 64), {id, " R10 error flag"}, err, int'(v.bad) < 64);
    check(rn == ex_reads, {id, " R5 read bytes delivered"}, rn, ex_reads);
    for (int i = 0; i < rn && i < ex_reads; i++)
      check(rcap[i] == 8'h30 + 8'(i), {id, " R5 read byte order"}, rcap[i], 8'h30 + i);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", nchk + 1, nerr + 1);
    $finish;
  end

  initial begin
    bit got;
    logic err;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state: R1 R10
    check(!busy && req_ready, "R1 idle after reset", busy, 0);
    check(!eng_req && !done && !error && !rd_valid, "R10 outputs quiet after reset",
          {eng_req, done, error, rd_valid}, 0);

    // table walk
    for (int k = 0; k < NV; k++) begin
      prep(VECS[k]);
      launch(VECS[k]);
      wait_done(got, err);
      compare(VECS[k], got, err, $sformatf("vec%0d", k));
      @(negedge clk);
      check(!done, "R10 done lasts one cycle", done, 0);
    end

    // R8: standard mode waits for the bus
    v = '{1'b0, 1'b0, 3'd1, 16'h4321, 8'd1, 8'd255, 1'b0};
    prep(v);
    bus_busy = 1'b1;
    launch(v);
    repeat (30) @(negedge clk);
    check(busy && !eng_req && lidx == 0, "R8 no operation while bus busy", lidx, 0);
    bus_busy = 1'b0;
    wait_done(got, err);
    compare(v, got, err, "r8_release");

    // R7: fast mode ignores the busy indication
    v = '{1'b1, 1'b1, 3'd6, 16'hCAFE, 8'd1, 8'd255, 1'b0};
    prep(v);
    bus_busy = 1'b1;
    launch(v);
    wait_done(got, err);
    bus_busy = 1'b0;
    compare(v, got, err, "r7_fast_busy");

    // R1: request while busy is ignored
    v = '{1'b1, 1'b0, 3'd2, 16'h2468, 8'd4, 8'd255, 1'b0};
    prep(v);
    launch(v);
    repeat (3) @(negedge clk);
    req_write = 1'b0; req_len = 8'd2; req_valid = 1'b1;
    repeat (5) @(negedge clk);
    check(busy && !req_ready, "R1 still busy during extra request", req_ready, 0);
    req_valid = 1'b0;
    wait_done(got, err);
    compare(v, got, err, "r1_ignored");
    repeat (10) @(negedge clk);
    check(!busy && lidx == en, "R1 no second transfer", lidx, en);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule